// File: doc/BRIEF.md
# ADC Register Access SPI Sequencer

This block is an SPI master that handles configuration traffic to a multichannel delta-sigma converter. A host raises a one-cycle request that names one of three kinds of operation: write one 8-bit register, read one 8-bit register, or send a one-byte control command such as start, stop, reset or leave-continuous-readout. The block serialises the matching frame, drives the serial clock, the data-out line and the active-low chip select, and samples the data-in line.

A register access is three bytes long. The first byte combines a kind-specific opcode with the register address. The second byte is zero, telling the converter that exactly one register follows. The third byte carries the write data, or zero on a read while the register value comes back. Commands are a single byte. The converter needs several of its own clock periods to decode each byte, so the serial clock is produced by a divider and is kept at or below the converter's 2.048 MHz master clock. After the last bit, chip select is held low for a fixed guard time before it is released, and only then does the block report completion.

Top module: `adc_reg_seq`

## Requirements
- R1: A write request (req_kind = 0) sends 24 bits MSB first on mosi: 0x40 OR the 5-bit address, then 0x00, then req_wdata.
- R2: A read request (req_kind = 1) sends 0x20 OR the address, then 0x00, then 0x00. The 8 bits sampled from miso during the third byte appear on rdata in the cycle done is high, and rdata changes at no other time.
- R3: A command request (req_kind = 2) sends exactly 8 bits. req_cmd selects the opcode: 0 gives 0x02, 1 gives 0x04, 2 gives 0x06, 3 gives 0x08, 4 gives 0x0A, 5 gives 0x10, 6 gives 0x11 and 7 gives 0x12.
- R4: SPI mode 1 is used. sclk idles low, mosi changes only together with a rising sclk edge, and miso is sampled at the falling sclk edge.
- R5: Every sclk phase lasts SCLK_HALF clk cycles, and the first rising edge comes SCLK_HALF cycles after cs_n falls. The default is 31 cycles at 125 MHz, which gives about 2.016 MHz.
- R6: After the last falling sclk edge, cs_n stays low for HOLD_NS nanoseconds (rounded up to whole clk cycles; 250 cycles by default) and then rises.
- R7: busy is high from the cycle after an accepted request until done. done is high for exactly one cycle, in the same cycle in which cs_n returns high.
- R8: A request made while busy is high is ignored. It neither changes nor extends the frame in flight, and it starts no later frame.
- R9: A register request whose address is above 0x19, and any request with req_kind = 3, is ignored: busy stays low and cs_n stays high.
- R10: After reset, cs_n = 1, sclk = 0, mosi = 0, busy = 0, done = 0 and rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_kind | input | 2 | 0 write, 1 read, 2 command, 3 reserved |
| req_cmd | input | 3 | Command selector, used when req_kind = 2 |
| req_addr | input | 5 | Register address |
| req_wdata | input | 8 | Register write data |
| busy | output | 1 | A frame or its guard time is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last register value read |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the converter |

## Verification
A wrong bit counter or frame register shows up on mosi as a bad opcode or a frame of the wrong length, and the bench detects it when cs_n rises, at most one frame time after the request. A wrong divider or guard counter moves the sclk and cs_n edges by whole clk cycles, and the bench sees this as exact nanosecond mismatches in the first frame it checks. If miso is sampled on the wrong edge, or rdata is loaded at the wrong moment, the third byte's bits shift or the value changes outside done. The bench catches this because its model converter returns marker bytes in the first two byte times. A broken busy guard shows up as an extra chip-select frame or a changed frame.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int REG_ADDR_W = 5;
    localparam int FRAME_W    = 24;
    localparam int BYTE_W     = 8;
    localparam int BITCNT_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        KIND_WR  = 2'd0,
        KIND_RD  = 2'd1,
        KIND_CMD = 2'd2,
        KIND_RSV = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } seq_state_e;

    // Opcode for a one-byte control command
    function automatic logic [BYTE_W-1:0] cmd_opcode(input logic [2:0] sel);
        logic [BYTE_W-1:0] op;
        case (sel)
            3'd0:    op = 8'h02;
            3'd1:    op = 8'h04;
            3'd2:    op = 8'h06;
            3'd3:    op = 8'h08;
            3'd4:    op = 8'h0A;
            3'd5:    op = 8'h10;
            3'd6:    op = 8'h11;
            default: op = 8'h12;
        endcase
        return op;
    endfunction

    // Frame image, left aligned: the first bit to send is bit FRAME_W-1
    function automatic logic [FRAME_W-1:0] build_frame(
        input req_kind_e             kind,
        input logic [2:0]            sel,
        input logic [REG_ADDR_W-1:0] addr,
        input logic [BYTE_W-1:0]     wdata
    );
        logic [BYTE_W-1:0] a8;
        a8 = {{(BYTE_W-REG_ADDR_W){1'b0}}, addr};
        case (kind)
            KIND_WR:  return {8'h40 | a8, 8'h00, wdata};
            KIND_RD:  return {8'h20 | a8, 8'h00, 8'h00};
            KIND_CMD: return {cmd_opcode(sel), 16'h0000};
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_divcnt.sv
module adc_seq_divcnt #(
    parameter int LIMIT = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = en && (cnt_q == CW'(LIMIT - 1));
        cnt_d = cnt_q;
        if (!en || hit) cnt_d = '0;
        else            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (LIMIT > 1) begin : g_chk
            // R5: a pacing interval is never shorter than LIMIT cycles
            p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
                hit |=> !hit);
        end
    endgenerate

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               rise,
    input  logic               fall,
    input  logic               miso,
    output logic               tx_msb,
    output logic [BYTE_W-1:0]  rx_byte
);
    typedef struct packed {
        logic [FRAME_W-1:0] tx;
        logic [BYTE_W-1:0]  rx;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d = q;
        if (load)      d.tx = load_word;
        else if (rise) d.tx = {q.tx[FRAME_W-2:0], 1'b0};
        if (fall)      d.rx = {q.rx[BYTE_W-2:0], miso};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_msb  = q.tx[FRAME_W-1];
    assign rx_byte = q.rx;

    // R4: incoming data only moves on a falling-edge strobe
    p_rx_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(q.rx));

endmodule

// File: rtl/adc_reg_seq.sv
module adc_reg_seq
    import adc_seq_pkg::*;
#(
    parameter int CLK_HZ     = 125_000_000,
    parameter int SCLK_HALF  = 31,
    parameter int HOLD_NS    = 2000,
    parameter int MAX_ADDR   = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [2:0]  req_cmd,
    input  logic [4:0]  req_addr,
    input  logic [7:0]  req_wdata,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rdata,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n,
    input  logic        miso
);
    localparam longint HOLD_L   = (longint'(CLK_HZ) * longint'(HOLD_NS) + 64'd999_999_999)
                                  / 64'd1_000_000_000;
    localparam int     HOLD_CYC = (HOLD_L < 1) ? 1 : int'(HOLD_L);
    localparam logic [BITCNT_W-1:0] LAST_REG = BITCNT_W'(FRAME_W - 1);
    localparam logic [BITCNT_W-1:0] LAST_CMD = BITCNT_W'(BYTE_W - 1);

    typedef struct packed {
        seq_state_e          state;
        req_kind_e           kind;
        logic                sclk;
        logic                mosi;
        logic                cs_n;
        logic                done;
        logic [BYTE_W-1:0]   rdata;
        logic [BITCNT_W-1:0] nbits;
        logic [BITCNT_W-1:0] last;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state: ST_IDLE, kind: KIND_WR, sclk: 1'b0, mosi: 1'b0, cs_n: 1'b1,
        done: 1'b0, rdata: '0, nbits: '0, last: '0
    };

    seq_t d, q;

    logic               half_hit, hold_hit;
    logic               rise, fall, load;
    logic [FRAME_W-1:0] load_word;
    logic               tx_msb;
    logic [BYTE_W-1:0]  rx_byte;
    logic               req_ok;
    req_kind_e          kind_in;

    adc_seq_divcnt #(.LIMIT(SCLK_HALF)) u_half (
        .clk (clk), .rst_n (rst_n), .en (q.state == ST_SHIFT), .hit (half_hit)
    );

    adc_seq_divcnt #(.LIMIT(HOLD_CYC)) u_hold (
        .clk (clk), .rst_n (rst_n), .en (q.state == ST_HOLD), .hit (hold_hit)
    );

    adc_seq_shifter u_shf (
        .clk (clk), .rst_n (rst_n), .load (load), .load_word (load_word),
        .rise (rise), .fall (fall), .miso (miso),
        .tx_msb (tx_msb), .rx_byte (rx_byte)
    );

    always_comb begin
        kind_in = req_kind_e'(req_kind);
        req_ok  = (kind_in == KIND_CMD) ||
                  (((kind_in == KIND_WR) || (kind_in == KIND_RD)) &&
                   (int'(req_addr) <= MAX_ADDR));
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        rise      = 1'b0;
        fall      = 1'b0;
        load      = 1'b0;
        load_word = '0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid && req_ok) begin
                    d.state   = ST_SHIFT;
                    d.kind    = kind_in;
                    d.cs_n    = 1'b0;
                    d.sclk    = 1'b0;
                    d.nbits   = '0;
                    d.last    = (kind_in == KIND_CMD) ? LAST_CMD : LAST_REG;
                    load      = 1'b1;
                    load_word = build_frame(kind_in, req_cmd, req_addr, req_wdata);
                end
            end
            ST_SHIFT: begin
                if (half_hit) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        d.mosi = tx_msb;
                        rise   = 1'b1;
                    end else begin
                        d.sclk = 1'b0;
                        fall   = 1'b1;
                        if (q.nbits == q.last) d.state = ST_HOLD;
                        else                   d.nbits = q.nbits + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (hold_hit) begin
                    d.state = ST_IDLE;
                    d.cs_n  = 1'b1;
                    d.done  = 1'b1;
                    if (q.kind == KIND_RD) d.rdata = rx_byte;
                end
            end
            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign busy  = (q.state != ST_IDLE);
    assign done  = q.done;
    assign rdata = q.rdata;
    assign sclk  = q.sclk;
    assign mosi  = q.mosi;
    assign cs_n  = q.cs_n;

    // R6: chip select is released whenever the engine is idle
    p_idle_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);
    // R4: clock parks low outside a frame
    p_sclk_parks_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R4: data out only moves with a rising clock edge
    p_mosi_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $rose(sclk));
    // R7: completion is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: completion coincides with release of chip select
    p_done_with_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));
    // R2: read value only moves on completion
    p_rdata_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));
    // R8: frame kind does not change while busy
    p_kind_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.kind));
    // R3: command frames finish after one byte
    p_cmd_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HOLD && q.kind == KIND_CMD) |-> (q.nbits == LAST_CMD));

endmodule

// File: tb/adc_reg_seq_test.sv
`timescale 1ns/1ps
module adc_reg_seq_test;

    localparam int HALF_NS = 31 * 8;
    localparam int HOLD_T  = 250 * 8;

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  cmd;
        logic [4:0]  addr;
        logic [7:0]  wdata;
        logic [7:0]  slave;
        logic [4:0]  nbits;
        logic [23:0] frame;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{kind: 2'd0, cmd: 3'd0, addr: 5'h01, wdata: 8'h86, slave: 8'h00, nbits: 5'd24, frame: 24'h410086},
        '{kind: 2'd0, cmd: 3'd0, addr: 5'h19, wdata: 8'h5A, slave: 8'h00, nbits: 5'd24, frame: 24'h59005A},
        '{kind: 2'd1, cmd: 3'd0, addr: 5'h00, wdata: 8'hFF, slave: 8'h92, nbits: 5'd24, frame: 24'h200000},
        '{kind: 2'd1, cmd: 3'd0, addr: 5'h12, wdata: 8'h00, slave: 8'hA5, nbits: 5'd24, frame: 24'h320000},
        '{kind: 2'd2, cmd: 3'd6, addr: 5'h1F, wdata: 8'h00, slave: 8'h00, nbits: 5'd8,  frame: 24'h000011},
        '{kind: 2'd2, cmd: 3'd3, addr: 5'h00, wdata: 8'h00, slave: 8'h00, nbits: 5'd8,  frame: 24'h000008},
        '{kind: 2'd2, cmd: 3'd0, addr: 5'h00, wdata: 8'h00, slave: 8'h00, nbits: 5'd8,  frame: 24'h000002},
        '{kind: 2'd1, cmd: 3'd0, addr: 5'h13, wdata: 8'h00, slave: 8'h3C, nbits: 5'd24, frame: 24'h330000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [2:0] req_cmd = '0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic busy, done, sclk, mosi, cs_n;
    logic [7:0] rdata;
    logic miso = 1'b0;

    int tests = 0;
    int fails = 0;

    logic [23:0] cap;
    int          nbits_seen;
    int          nframes = 0;
    logic [23:0] slv;
    time t_csf, t_r1, t_f1, t_flast, t_csr;
    bit  first_r, first_f;

    always #4 clk = ~clk;

    adc_reg_seq uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_kind (req_kind),
        .req_cmd (req_cmd), .req_addr (req_addr), .req_wdata (req_wdata),
        .busy (busy), .done (done), .rdata (rdata), .sclk (sclk), .mosi (mosi),
        .cs_n (cs_n), .miso (miso)
    );

    // Converter model: drives miso on rising, captures mosi on falling
    always @(negedge cs_n) begin
        t_csf = $time; first_r = 1'b1; first_f = 1'b1;
        cap = '0; nbits_seen = 0; nframes++;
    end
    always @(posedge cs_n) t_csr = $time;
    always @(posedge sclk) begin
        if (first_r) begin t_r1 = $time; first_r = 1'b0; end
        miso = slv[23];
        slv  = {slv[22:0], 1'b0};
    end
    always @(negedge sclk) begin
        if (first_f) begin t_f1 = $time; first_f = 1'b0; end
        t_flast = $time;
        if (!cs_n) begin cap = {cap[22:0], mosi}; nbits_seen++; end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [2:0] c,
                         input logic [4:0] a, input logic [7:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_cmd = c; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Waits for done at negedges; checks pulse shape
    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        check(done === 1'b1, req, {31'd0, done}, 32'd1);
        check(cs_n === 1'b1 && busy === 1'b0, "R7 cs_n/busy at done",
              {30'd0, cs_n, busy}, 32'h2);
        @(negedge clk);
        check(done === 1'b0, "R7 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] exp_rd;
        slv = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(cs_n === 1'b1, "R10 cs_n", {31'd0, cs_n}, 32'd1);
        check(sclk === 1'b0 && mosi === 1'b0, "R10 sclk/mosi", {30'd0, sclk, mosi}, 32'd0);
        check(busy === 1'b0 && done === 1'b0, "R10 busy/done", {30'd0, busy, done}, 32'd0);
        check(rdata === 8'h00, "R10 rdata", {24'd0, rdata}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        exp_rd = 8'h00;

        for (int i = 0; i < NV; i++) begin
            slv = {8'hC3, 8'h7E, VEC[i].slave};
            issue(VEC[i].kind, VEC[i].cmd, VEC[i].addr, VEC[i].wdata);
            check(busy === 1'b1 && cs_n === 1'b0, "R7 busy after accept",
                  {30'd0, busy, cs_n}, 32'h2);
            wait_done("R7 done seen");
            check(nbits_seen == int'(VEC[i].nbits), "R3 bit count (R1 R2 frames)",
                  nbits_seen, VEC[i].nbits);
            if (VEC[i].kind == 2'd0)
                check(cap == VEC[i].frame, "R1 write frame", cap, VEC[i].frame);
            else if (VEC[i].kind == 2'd1)
                check(cap == VEC[i].frame, "R2 read frame", cap, VEC[i].frame);
            else
                check(cap[7:0] == VEC[i].frame[7:0], "R3 command opcode", cap[7:0], VEC[i].frame[7:0]);
            if (VEC[i].kind == 2'd1) exp_rd = VEC[i].slave;
            check(rdata === exp_rd, "R2 R4 rdata from third byte on falling edge", rdata, exp_rd);
            check((t_r1 - t_csf) == HALF_NS, "R5 cs_n fall to first rise",
                  32'(t_r1 - t_csf), HALF_NS);
            check((t_f1 - t_r1) == HALF_NS, "R5 sclk half period",
                  32'(t_f1 - t_r1), HALF_NS);
            check((t_csr - t_flast) == HOLD_T, "R6 chip select hold",
                  32'(t_csr - t_flast), HOLD_T);
            check(sclk === 1'b0, "R4 sclk idles low", {31'd0, sclk}, 32'd0);
            repeat (3) @(negedge clk);
        end

        // R8: request during a frame is ignored
        begin
            int nf;
            nf = nframes;
            slv = {8'hC3, 8'h7E, 8'hEE};
            issue(2'd0, 3'd0, 5'h02, 8'h11);
            repeat (100) @(negedge clk);
            issue(2'd1, 3'd0, 5'h05, 8'h00);
            wait_done("R8 done seen");
            check(cap == 24'h420011, "R8 frame untouched", cap, 24'h420011);
            repeat (200) @(negedge clk);
            check(nframes == nf + 1, "R8 no extra frame", nframes, nf + 1);
            check(rdata === exp_rd, "R8 rdata untouched", rdata, exp_rd);
        end

        // R9: out-of-range address and reserved kind are ignored
        begin
            int nf;
            nf = nframes;
            issue(2'd0, 3'd0, 5'h1A, 8'h33);
            check(busy === 1'b0 && cs_n === 1'b1, "R9 addr 0x1A ignored",
                  {30'd0, busy, cs_n}, 32'h1);
            issue(2'd1, 3'd0, 5'h1F, 8'h00);
            check(busy === 1'b0, "R9 read addr 0x1F ignored", {31'd0, busy}, 32'd0);
            issue(2'd3, 3'd2, 5'h01, 8'h00);
            check(busy === 1'b0, "R9 reserved kind ignored", {31'd0, busy}, 32'd0);
            repeat (50) @(negedge clk);
            check(nframes == nf && cs_n === 1'b1, "R9 no frame", nframes, nf);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule